// File: doc/BRIEF.md
# Operand-Gathering Computation Unit Controller

This controller sits between an issue stage, a register file and a pipelined ALU. A one-cycle issue pulse hands it an operation. It latches the opcode together with the two substitution flags (port A forced to zero, port B replaced by an immediate) and the immediate value, and raises busy. Every source port still needed after substitution and masking then asks the register file for its operand with its own request line. It takes the value on a one-cycle go pulse and holds it for the ALU.

Once no unmasked source is outstanding, the unit offers the gathered operands to the ALU with a valid/accept handshake. When the ALU reports done, each result port that the ALU flags as produced raises its own write request. It releases the ALU's result on a one-cycle write go. Results the ALU does not produce are flagged on a write-mask output instead. The unit answers the ALU's done with ready once every requested result has been released, or is being released in that cycle, and busy falls in the next cycle. A read mask is supplied by the issuer and held for the whole busy period. It suppresses individual reads. When every port is masked the operation is a no-op: the ALU is never invoked and no transfer takes place.

Vector bit i of every read-side signal belongs to source port i, and `src_i[i*W +: W]` carries its data. Port 0 is operand A (zero substitution) and port 1 is operand B (immediate substitution). Result port j uses bit j and `dest_o[j*W +: W]`, in the same way.

Top module: `opgather_cu`

## Requirements
- R1: An issue pulse while idle latches `op_i`, `zero_a_i`, `imm_ok_i` and `imm_i`, and busy is high in the following cycle. These inputs may change from the next cycle on without affecting the operation, and `alu_op_o` carries the latched opcode.
- R2: Busy is low from reset until the first issue. The issuer never raises issue while busy is high.
- R3: For each source port that is needed and unmasked, the read request rises in the cycle after issue. It stays high for as long as go is withheld and falls in the cycle after the go cycle. A go in the first request cycle is accepted, and the operand is sampled only in the go cycle.
- R4: With `zero_a_i` set, port 0 raises no read request and the ALU receives zero as operand 0.
- R5: With `imm_ok_i` set, port 1 raises no read request and the ALU receives the latched immediate as operand 1.
- R6: Read-mask bit i high (held for the whole busy period, not latched) keeps port i from raising a read request and presents zero to the ALU on operand i. The mask takes precedence over substitution.
- R7: When every read-mask bit is high, the operation is a no-op. Busy is high for exactly one cycle, the ALU is never offered valid, and no read or write request is raised.
- R8: ALU valid is raised only once no unmasked read is outstanding, and it stays high until accepted. The operands at acceptance are the gathered or substituted values.
- R9: While the ALU reports done, result port j raises a write request if `alu_res_ok_i[j]` is 1, with `dest_o` slice j equal to the ALU result. The request falls after its go. `wr_mask_o[j]` is high instead when the ALU flags that result as not produced.
- R10: ALU ready is high only while done is reported and every requested result is released or released in that cycle. Busy falls in the cycle after the last write go, or in the cycle after done when no result is requested.
- R11: After reset all requests are low, busy and ALU valid are low, and `alu_op_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | One-cycle issue pulse |
| op_i | input | OPW | Opcode presented with issue |
| zero_a_i | input | 1 | Force operand 0 to zero, skip its read |
| imm_ok_i | input | 1 | Use imm_i as operand 1, skip its read |
| imm_i | input | W | Immediate value |
| rd_mask_i | input | NSRC | Per-port read suppression, high = masked, held while busy |
| busy_o | output | 1 | Operation in progress |
| rd_req_o | output | NSRC | Per-port read request |
| rd_go_i | input | NSRC | Per-port read go pulse |
| src_i | input | NSRC*W | Per-port operand data, valid in the go cycle |
| alu_op_o | output | OPW | Latched opcode to the ALU |
| alu_src_o | output | NSRC*W | Gathered operands to the ALU |
| alu_valid_o | output | 1 | Operands ready for the ALU |
| alu_accept_i | input | 1 | ALU accepts operands |
| alu_done_i | input | 1 | ALU result available, held until ready |
| alu_res_i | input | NDST*W | ALU results |
| alu_res_ok_i | input | NDST | Per-result produced flag |
| alu_ready_o | output | 1 | Unit has released all results |
| wr_req_o | output | NDST | Per-port write request |
| wr_go_i | input | NDST | Per-port write go pulse |
| wr_mask_o | output | NDST | Result will not be produced |
| dest_o | output | NDST*W | Result data, valid in the go cycle |

## Verification
The final write go and the completion handshake with the ALU fall in the same cycle. Ready looks ahead at that cycle's go, so busy must drop in the very next cycle with nothing lost or repeated. The bench provokes this with equal or zero write delays on both result ports, so that both gos land together with the ALU's done held. It also uses staggered delays, so that the last go follows the first. It judges each case by busy falling exactly one cycle after the last go and by per-port transfer counts that match the operation's needs. A second coincidence, both read gos in one cycle and a go in the very first request cycle, is judged by the operands the bench ALU captures.

// File: rtl/opg_pkg.sv
package opg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GATHER = 2'd1,
    ST_EXEC   = 2'd2
  } opg_state_e;
endpackage

// File: rtl/opg_rd_port.sv
module opg_rd_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         fixed_i,
  input  logic [W-1:0] fix_val_i,
  input  logic         mask_i,
  input  logic         go_i,
  input  logic [W-1:0] data_i,
  input  logic         clear_i,
  output logic         req_o,
  output logic [W-1:0] opnd_o
);
  logic         pend;
  logic [W-1:0] val;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      val  <= '0;
    end else if (start_i) begin
      pend <= ~fixed_i;
      val  <= fixed_i ? fix_val_i : '0;
    end else if (clear_i) begin
      pend <= 1'b0;
    end else if (req_o && go_i) begin
      pend <= 1'b0;
      val  <= data_i;
    end
  end

  assign req_o  = pend & ~mask_i;
  assign opnd_o = mask_i ? '0 : val;

  // R3: request is held while go is withheld
  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    (req_o && !go_i) |=> req_o);
  // R3: request falls after the go cycle
  a_r3_req_fall: assert property (@(posedge clk) disable iff (rst)
    (req_o && go_i) |=> !req_o);
  // R3: operand taken in the go cycle
  a_r3_capture: assert property (@(posedge clk) disable iff (rst)
    (req_o && go_i) |=> (opnd_o == $past(data_i)));
endmodule

// File: rtl/opg_wr_port.sv
module opg_wr_port (
  input  logic clk,
  input  logic rst,
  input  logic avail_i,
  input  logic ok_i,
  input  logic go_i,
  input  logic clear_i,
  output logic req_o,
  output logic mask_o,
  output logic open_o
);
  logic done;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      done <= 1'b0;
    end else if (req_o && go_i) begin
      done <= 1'b1;
    end
  end

  assign req_o  = avail_i & ok_i & ~done;
  assign mask_o = avail_i & ~ok_i;
  assign open_o = req_o & ~go_i;

  // R9: one write per result, request falls after go
  a_r9_req_fall: assert property (@(posedge clk) disable iff (rst)
    (req_o && go_i) |=> !req_o);
endmodule

// File: rtl/opg_ctl.sv
module opg_ctl
  import opg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic issue_i,
  input  logic gathered_i,
  input  logic nop_i,
  input  logic alu_accept_i,
  input  logic alu_done_i,
  input  logic released_i,
  output logic busy_o,
  output logic start_o,
  output logic finish_o,
  output logic exec_o,
  output logic alu_valid_o,
  output logic alu_ready_o
);
  opg_state_e state;
  logic       in_gather;

  assign in_gather   = (state == ST_GATHER);
  assign exec_o      = (state == ST_EXEC);
  assign busy_o      = (state != ST_IDLE);
  assign start_o     = (state == ST_IDLE) & issue_i;
  assign alu_valid_o = in_gather & gathered_i & ~nop_i;
  assign alu_ready_o = exec_o & alu_done_i & released_i;
  assign finish_o    = (in_gather & nop_i) | alu_ready_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:   if (start_o) state <= ST_GATHER;
        ST_GATHER: begin
          if (nop_i) state <= ST_IDLE;
          else if (alu_valid_o && alu_accept_i) state <= ST_EXEC;
        end
        ST_EXEC:   if (alu_ready_o) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R2: issue never coincides with busy
  a_r2_no_issue_busy: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !issue_i);
  // R1: busy follows an issue
  a_r1_busy_rise: assert property (@(posedge clk) disable iff (rst)
    (issue_i && !busy_o) |=> busy_o);
  // R7: no-op lasts one busy cycle and never offers valid
  a_r7_nop_short: assert property (@(posedge clk) disable iff (rst)
    (in_gather && nop_i) |=> !busy_o);
  a_r7_nop_novalid: assert property (@(posedge clk) disable iff (rst)
    nop_i |-> !alu_valid_o);
  // R8: valid held until accepted
  a_r8_valid_hold: assert property (@(posedge clk) disable iff (rst)
    (alu_valid_o && !alu_accept_i) |=> alu_valid_o);
  // R10: busy falls after the completion handshake
  a_r10_busy_fall: assert property (@(posedge clk) disable iff (rst)
    (alu_done_i && alu_ready_o) |=> !busy_o);
endmodule

// File: rtl/opgather_cu.sv
module opgather_cu #(
  parameter int W    = 16,
  parameter int NSRC = 2,
  parameter int NDST = 2,
  parameter int OPW  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               issue_i,
  input  logic [OPW-1:0]     op_i,
  input  logic               zero_a_i,
  input  logic               imm_ok_i,
  input  logic [W-1:0]       imm_i,
  input  logic [NSRC-1:0]    rd_mask_i,
  output logic               busy_o,
  output logic [NSRC-1:0]    rd_req_o,
  input  logic [NSRC-1:0]    rd_go_i,
  input  logic [NSRC*W-1:0]  src_i,
  output logic [OPW-1:0]     alu_op_o,
  output logic [NSRC*W-1:0]  alu_src_o,
  output logic               alu_valid_o,
  input  logic               alu_accept_i,
  input  logic               alu_done_i,
  input  logic [NDST*W-1:0]  alu_res_i,
  input  logic [NDST-1:0]    alu_res_ok_i,
  output logic               alu_ready_o,
  output logic [NDST-1:0]    wr_req_o,
  input  logic [NDST-1:0]    wr_go_i,
  output logic [NDST-1:0]    wr_mask_o,
  output logic [NDST*W-1:0]  dest_o
);
  localparam int PORT_A = 0;
  localparam int PORT_B = 1;

  logic            start, finish, exec, gathered, nop, released;
  logic [NDST-1:0] wr_open;
  logic [OPW-1:0]  op_q;

  assign gathered = ~|rd_req_o;
  assign nop      = &rd_mask_i;
  assign released = ~|wr_open;
  assign alu_op_o = op_q;
  assign dest_o   = alu_res_i;

  always_ff @(posedge clk) begin
    if (rst) op_q <= '0;
    else if (start) op_q <= op_i;
  end

  opg_ctl u_ctl (
    .clk(clk), .rst(rst), .issue_i(issue_i), .gathered_i(gathered),
    .nop_i(nop), .alu_accept_i(alu_accept_i), .alu_done_i(alu_done_i),
    .released_i(released), .busy_o(busy_o), .start_o(start),
    .finish_o(finish), .exec_o(exec), .alu_valid_o(alu_valid_o),
    .alu_ready_o(alu_ready_o)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_rd
    logic         fx;
    logic [W-1:0] fv;
    if (g == PORT_A) begin : g_a
      assign fx = zero_a_i;
      assign fv = '0;
    end else if (g == PORT_B) begin : g_b
      assign fx = imm_ok_i;
      assign fv = imm_i;
    end else begin : g_plain
      assign fx = 1'b0;
      assign fv = '0;
    end
    opg_rd_port #(.W(W)) u_rd (
      .clk(clk), .rst(rst), .start_i(start), .fixed_i(fx), .fix_val_i(fv),
      .mask_i(rd_mask_i[g]), .go_i(rd_go_i[g]), .data_i(src_i[g*W +: W]),
      .clear_i(finish), .req_o(rd_req_o[g]), .opnd_o(alu_src_o[g*W +: W])
    );
  end

  for (genvar j = 0; j < NDST; j++) begin : g_wr
    opg_wr_port u_wr (
      .clk(clk), .rst(rst), .avail_i(exec & alu_done_i),
      .ok_i(alu_res_ok_i[j]), .go_i(wr_go_i[j]), .clear_i(finish),
      .req_o(wr_req_o[j]), .mask_o(wr_mask_o[j]), .open_o(wr_open[j])
    );
  end

  // R4: zero substitution suppresses the port A read
  a_r4_zero_a: assert property (@(posedge clk) disable iff (rst)
    (start && zero_a_i) |=> !rd_req_o[PORT_A]);
  // R5: immediate suppresses the port B read and reaches the ALU
  a_r5_imm_noreq: assert property (@(posedge clk) disable iff (rst)
    (start && imm_ok_i) |=> !rd_req_o[PORT_B]);
  a_r5_imm_val: assert property (@(posedge clk) disable iff (rst)
    (start && imm_ok_i && !rd_mask_i[PORT_B]) |=>
      (alu_src_o[PORT_B*W +: W] == $past(imm_i)));
  // R1: opcode latched at issue
  a_r1_op_latch: assert property (@(posedge clk) disable iff (rst)
    start |=> (alu_op_o == $past(op_i)));
  // R10: no write request outside busy
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (wr_req_o == '0 && rd_req_o == '0));
endmodule

// File: tb/opgather_cu_bench.sv
module opgather_cu_bench;
  localparam int W = 16, NSRC = 2, NDST = 2, OPW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic issue_i = 0, zero_a_i = 0, imm_ok_i = 0;
  logic [OPW-1:0] op_i = '0;
  logic [W-1:0] imm_i = '0;
  logic [NSRC-1:0] rd_mask_i = '0, rd_go = '0, rd_req_o;
  logic [NSRC*W-1:0] src = '0, alu_src_o;
  logic busy_o, alu_valid_o, alu_ready_o;
  logic [OPW-1:0] alu_op_o;
  logic alu_accept = 0, alu_done = 0;
  logic [NDST*W-1:0] alu_res = '0, dest_o;
  logic [NDST-1:0] alu_ok = '0, wr_go = '0, wr_req_o, wr_mask_o;

  always #10 clk = ~clk;

  opgather_cu #(.W(W), .NSRC(NSRC), .NDST(NDST), .OPW(OPW)) u_opgather_cu (
    .clk(clk), .rst(rst), .issue_i(issue_i), .op_i(op_i), .zero_a_i(zero_a_i),
    .imm_ok_i(imm_ok_i), .imm_i(imm_i), .rd_mask_i(rd_mask_i), .busy_o(busy_o),
    .rd_req_o(rd_req_o), .rd_go_i(rd_go), .src_i(src), .alu_op_o(alu_op_o),
    .alu_src_o(alu_src_o), .alu_valid_o(alu_valid_o), .alu_accept_i(alu_accept),
    .alu_done_i(alu_done), .alu_res_i(alu_res), .alu_res_ok_i(alu_ok),
    .alu_ready_o(alu_ready_o), .wr_req_o(wr_req_o), .wr_go_i(wr_go),
    .wr_mask_o(wr_mask_o), .dest_o(dest_o)
  );

  int total = 0, bad = 0, cyc = 0, last_go = -1, alu_calls = 0;
  logic [W-1:0] p_data [NSRC];
  int p_delay [NSRC], p_wait [NSRC], p_count [NSRC];
  int c_delay [NDST], c_wait [NDST], c_count [NDST];
  logic [W-1:0] exp_w [NDST];
  logic [NSRC-1:0] need_r = '0;
  logic [NDST-1:0] need_w = '0, saw_mask = '0;
  logic stray = 0;
  logic [W-1:0] e_a = '0, e_b = '0;
  logic [OPW-1:0] e_op = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit c, input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [W-1:0] fn0(input logic [OPW-1:0] op, input logic [W-1:0] a, b);
    case (op[1:0])
      2'd0: fn0 = a + b;
      2'd1: fn0 = a - b;
      2'd2: fn0 = a ^ b;
      default: fn0 = a & b;
    endcase
  endfunction

  function automatic logic [W-1:0] fn1(input logic [W-1:0] a, b);
    fn1 = a | b;
  endfunction

  // operand producers
  initial begin
    for (int i = 0; i < NSRC; i++) begin p_delay[i] = 0; p_wait[i] = 0; p_count[i] = 0; p_data[i] = '0; end
    forever begin
      @(negedge clk); #2;
      for (int i = 0; i < NSRC; i++) begin
        if (rd_go[i]) begin
          rd_go[i] = 1'b0; src[i*W +: W] = '0;
          chk(rd_req_o[i] == 1'b0, "R3 req falls after go", rd_req_o[i], 0);
        end else if (rd_req_o[i]) begin
          if (!need_r[i]) stray = 1'b1;
          if (p_wait[i] == 0) begin
            rd_go[i] = 1'b1; src[i*W +: W] = p_data[i]; p_count[i]++;
          end else p_wait[i]--;
        end else p_wait[i] = p_delay[i];
      end
    end
  end

  // result consumers
  initial begin
    for (int j = 0; j < NDST; j++) begin c_delay[j] = 0; c_wait[j] = 0; c_count[j] = 0; exp_w[j] = '0; end
    forever begin
      @(negedge clk); #2;
      for (int j = 0; j < NDST; j++) begin
        if (wr_mask_o[j]) saw_mask[j] = 1'b1;
        if (wr_go[j]) begin
          wr_go[j] = 1'b0;
          chk(wr_req_o[j] == 1'b0, "R9 write req falls after go", wr_req_o[j], 0);
        end else if (wr_req_o[j]) begin
          if (!need_w[j]) stray = 1'b1;
          if (c_wait[j] == 0) begin
            wr_go[j] = 1'b1; c_count[j]++; last_go = cyc;
            chk(dest_o[j*W +: W] == exp_w[j], "R9 result data", dest_o[j*W +: W], exp_w[j]);
          end else c_wait[j]--;
        end else c_wait[j] = c_delay[j];
      end
    end
  end

  // bench ALU model
  initial begin
    logic alu_b, rel_next;
    logic [W-1:0] ca, cb;
    logic [OPW-1:0] cop;
    int lat;
    alu_b = 0; rel_next = 0; lat = 0; ca = '0; cb = '0; cop = '0;
    forever begin
      @(negedge clk);
      if (rel_next) begin alu_done = 0; alu_ok = '0; alu_b = 0; rel_next = 0; end
      if (!alu_b) alu_accept = (($urandom % 3) != 0);
      else begin
        alu_accept = 1'b0;
        if (!alu_done) begin
          if (lat == 0) begin
            alu_done = 1'b1; alu_res = {fn1(ca, cb), fn0(cop, ca, cb)}; alu_ok = cop[3:2];
          end else lat--;
        end
      end
      #4;
      if (!alu_b && alu_valid_o && alu_accept) begin
        ca = alu_src_o[W-1:0]; cb = alu_src_o[2*W-1:W]; cop = alu_op_o;
        chk(ca == e_a, "R8 operand 0 at accept (R4 R6)", ca, e_a);
        chk(cb == e_b, "R8 operand 1 at accept (R5 R6)", cb, e_b);
        chk(cop == e_op, "R1 latched opcode", cop, e_op);
        alu_b = 1; lat = $urandom % 3; alu_calls++;
      end
      if (alu_done && alu_ready_o) rel_next = 1'b1;
    end
  end

  task automatic run_op(input logic [OPW-1:0] op, input logic [W-1:0] a, b, imm,
                        input logic za, io, input logic [NSRC-1:0] msk,
                        input int d0, d1, e0, e1);
    logic nop;
    int pc [NSRC];
    int cc [NDST];
    int calls0, n;
    nop = &msk;
    need_r[0] = !za && !msk[0];
    need_r[1] = !io && !msk[1];
    e_a = (za || msk[0]) ? '0 : a;
    e_b = msk[1] ? '0 : (io ? imm : b);
    e_op = op;
    need_w[0] = op[2] && !nop;
    need_w[1] = op[3] && !nop;
    exp_w[0] = fn0(op, e_a, e_b);
    exp_w[1] = fn1(e_a, e_b);
    for (int i = 0; i < NSRC; i++) pc[i] = p_count[i];
    for (int j = 0; j < NDST; j++) cc[j] = c_count[j];
    calls0 = alu_calls;
    @(negedge clk);
    stray = 0; saw_mask = '0; last_go = -1;
    #1 chk(busy_o == 1'b0, "R2 idle before issue", busy_o, 0);
    p_data[0] = a; p_data[1] = b; p_delay[0] = d0; p_delay[1] = d1;
    c_delay[0] = e0; c_delay[1] = e1;
    issue_i = 1; op_i = op; imm_i = imm; zero_a_i = za; imm_ok_i = io; rd_mask_i = msk;
    @(negedge clk);
    issue_i = 0; op_i = ~op; imm_i = ~imm; zero_a_i = ~za; imm_ok_i = ~io;
    #1;
    chk(busy_o == 1'b1, "R1 busy after issue", busy_o, 1);
    chk(rd_req_o == need_r, "R3 requests in first cycle", rd_req_o, need_r);
    n = 0;
    while (busy_o && n < 300) begin @(negedge clk); #1; n++; end
    chk(n < 300, "R10 operation completes", n, 0);
    if (nop) chk(n == 1, "R7 no-op busy one cycle", n, 1);
    if (need_w != '0) chk(cyc - last_go == 1, "R10 busy falls after last go", cyc - last_go, 1);
    rd_mask_i = '0;
    for (int i = 0; i < NSRC; i++)
      chk(p_count[i] - pc[i] == int'(need_r[i]), "R3 read count (R4 R5 R6 R7)", p_count[i] - pc[i], need_r[i]);
    for (int j = 0; j < NDST; j++)
      chk(c_count[j] - cc[j] == int'(need_w[j]), "R9 write count (R7)", c_count[j] - cc[j], need_w[j]);
    chk(stray == 1'b0, "R6 no request on skipped port", stray, 0);
    chk(saw_mask == (~need_w & {NDST{!nop}}), "R9 write mask", saw_mask, ~need_w & {NDST{!nop}});
    chk(alu_calls - calls0 == int'(!nop), "R7 ALU invoked iff not no-op", alu_calls - calls0, !nop);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk(busy_o == 0, "R11 reset busy", busy_o, 0);
    chk(rd_req_o == 0 && wr_req_o == 0, "R11 reset requests", {rd_req_o, wr_req_o}, 0);
    chk(alu_valid_o == 0 && alu_op_o == 0, "R11 reset valid and opcode", {alu_valid_o, alu_op_o}, 0);
    rst = 0;
    repeat (2) @(negedge clk);
    #1 chk(busy_o == 0, "R2 busy stays low without issue", busy_o, 0);
    // directed corners
    run_op(4'b1100, 16'd5, 16'd2, 16'd0, 0, 0, 2'b00, 0, 0, 0, 0);
    run_op(4'b0100, 16'd5, 16'd2, 16'd8, 1, 1, 2'b00, 1, 1, 2, 2);
    run_op(4'b1101, 16'd30, 16'd9, 16'd7, 0, 1, 2'b00, 2, 0, 0, 3);
    run_op(4'b1100, 16'd5, 16'd2, 16'd8, 0, 0, 2'b11, 1, 2, 1, 0);
    run_op(4'b1110, 16'h80, 16'd2, 16'd0, 0, 0, 2'b01, 2, 1, 1, 1);
    run_op(4'b0000, 16'd3, 16'd4, 16'd0, 0, 0, 2'b00, 0, 3, 0, 0);
    run_op(4'b1100, 16'd9, 16'd2, 16'd55, 0, 1, 2'b10, 0, 0, 2, 0);
    run_op(4'b1000, 16'd3, 16'd4, 16'd0, 1, 0, 2'b00, 0, 2, 0, 1);
    // constrained random
    for (int k = 0; k < 40; k++) begin
      logic [NSRC-1:0] m;
      m = (($urandom % 5) == 0) ? 2'($urandom) : 2'b00;
      run_op(4'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
             (($urandom % 4) == 0), (($urandom % 4) == 0), m,
             $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule